// File: doc/BRIEF.md
# Serial Auto-Baud Search Controller

This controller drives the rate selection of a UART receiver whose host runs at an unknown baud rate. After reset it raises both modem handshake outputs and waits for carrier detect. It then works down a fixed table of sixteen rates, starting at the fastest. At each rate it compares every byte the receiver delivers against the test pattern 0x55. Ten misses at one rate move the search one rate slower. Ten misses at the slowest rate send it back to the fastest.

A single clean 0x55 does not lock the rate on its own. It opens a confirmation window, and ten more clean 0x55 bytes must follow before the rate is declared found. A wrong byte or any receive error inside that window sends the search back to the fastest rate. Once locked, the rate index is frozen until carrier detect drops or reset is applied.

The rate index drives a 16x-oversampling divisor of a 5.0688 MHz reference. The receiver it steers is expected to be set for 8 data bits with odd parity.

Top module: `baud_hunt_ctrl`

## Requirements
- R1: While `rst_n` is low, `dtr_o` and `rts_o` are 0, `rate_idx_o` is 15 and only `waiting_o` is set. From the first clock edge after reset is released, `dtr_o` and `rts_o` are 1.
- R2: While carrier detect is low, the controller stays in the waiting state with `rate_idx_o` = 15, and received bytes and error flags have no effect.
- R3: One clock after carrier detect rises in the waiting state, `hunting_o` is set and the index is 15, which is 19200 baud.
- R4: While hunting, a byte counts as a miss if its value is not 0x55 or if any error flag is set with its strobe. The tenth miss at one index moves the index down by one, and the next rate starts again from zero misses.
- R5: The tenth miss at index 0 (50 baud) sets the index to 15 and hunting continues.
- R6: A clean 0x55 while hunting sets `confirming_o` and keeps the index. The tenth further clean 0x55 sets `locked_o`; the ninth does not.
- R7: While confirming, a byte other than 0x55, or an overrun, framing or parity flag (with or without the strobe), returns the controller to hunting at index 15 with zero misses.
- R8: While locked with carrier present, `rate_idx_o` and `divisor_o` do not change, and bytes and error flags have no effect.
- R9: Carrier detect low in any state other than waiting returns the controller, one clock later, to waiting with index 15.
- R10: Index i selects the rate 50, 75, 110, 134.5, 150, 300, 600, 1200, 1800, 2000, 2400, 3600, 4800, 7200, 9600 or 19200 baud for i = 0..15. `divisor_o` equals 5068800 / (16 x rate), rounded to the nearest integer with halves rounded up.
- R11: Exactly one of `waiting_o`, `hunting_o`, `confirming_o` and `locked_o` is set at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| carrier_det_i | input | 1 | Carrier detect from the modem |
| rx_data_i | input | 8 | Byte from the receiver |
| rx_valid_i | input | 1 | One-cycle strobe: `rx_data_i` holds a new byte |
| rx_overrun_i | input | 1 | Receiver overrun flag |
| rx_framing_err_i | input | 1 | Receiver framing error flag |
| rx_parity_err_i | input | 1 | Receiver parity error flag |
| dtr_o | output | 1 | Data terminal ready |
| rts_o | output | 1 | Request to send |
| rate_idx_o | output | 4 | Selected rate index (0 slowest, 15 fastest) |
| divisor_o | output | 16 | 16x-oversampling divisor for the selected rate |
| waiting_o | output | 1 | Waiting for carrier |
| hunting_o | output | 1 | Searching for the rate |
| confirming_o | output | 1 | Inside the confirmation window |
| locked_o | output | 1 | Rate found and frozen |

## Verification
The hardest case to reach is the wrap from the slowest rate back to the fastest, which needs 160 misses in a row after carrier rises. A close second is a restart from the confirmation window at a low index. The bench models a host fixed at each of the sixteen rates. It feeds exactly the number of misses that the index arithmetic predicts, mixing wrong values with error-flagged 0x55 bytes, so that each index, its divisor and the full confirmation run are all reached. Separate sequences drive 160 straight misses, and inject each kind of error, strobed and unstrobed, inside confirmation windows opened at several indices.

// File: rtl/baud_hunt_pkg.sv
// Shared types and the rate list for the auto-baud search controller.
// Assumes a 4-bit rate index; rates are held in tenths of a baud so that
// the fractional rate stays exact.
package baud_hunt_pkg;

    typedef enum logic [1:0] {
        ST_WAIT    = 2'd0,
        ST_HUNT    = 2'd1,
        ST_CONFIRM = 2'd2,
        ST_LOCK    = 2'd3
    } hunt_state_t;

    // Rate in tenths of a baud for each index, slowest first.
    function automatic int unsigned rate_tenths(input int unsigned idx);
        case (idx)
            0:       rate_tenths = 500;
            1:       rate_tenths = 750;
            2:       rate_tenths = 1100;
            3:       rate_tenths = 1345;
            4:       rate_tenths = 1500;
            5:       rate_tenths = 3000;
            6:       rate_tenths = 6000;
            7:       rate_tenths = 12000;
            8:       rate_tenths = 18000;
            9:       rate_tenths = 20000;
            10:      rate_tenths = 24000;
            11:      rate_tenths = 36000;
            12:      rate_tenths = 48000;
            13:      rate_tenths = 72000;
            14:      rate_tenths = 96000;
            default: rate_tenths = 192000;
        endcase
    endfunction

endpackage

// File: rtl/baud_rate_rom.sv
// Maps a rate index to its oversampling divisor.
// Assumes REF_HZ * 10 fits in 32 bits; every divisor is rounded to nearest.
module baud_rate_rom #(
    parameter int unsigned REF_HZ = 5068800,
    parameter int unsigned OVS    = 16,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned DIV_W  = 16
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [DIV_W-1:0] divisor_o
);
    import baud_hunt_pkg::*;

    localparam int unsigned NRATES   = 1 << IDX_W;
    localparam int unsigned SCALED_F = (REF_HZ * 10) / OVS;

    logic [DIV_W-1:0] div_tab [NRATES];

    // One divisor per index, computed from the rate list.
    for (genvar g = 0; g < NRATES; g++) begin : g_tab
        localparam int unsigned RT = rate_tenths(g);
        assign div_tab[g] = DIV_W'((SCALED_F + RT / 2) / RT);
    end

    // Select the entry for the current index.
    assign divisor_o = div_tab[idx_i];

endmodule

// File: rtl/baud_byte_judge.sv
// Classifies one receiver event against the test pattern.
// Assumes the strobe is high for one cycle per byte.
module baud_byte_judge #(
    parameter int unsigned       DATA_W  = 8,
    parameter logic [DATA_W-1:0] PATTERN = 8'h55
) (
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              overrun_i,
    input  logic              framing_i,
    input  logic              parity_i,
    output logic              hit_o,
    output logic              miss_o,
    output logic              err_any_o
);
    // Merge the three receiver error flags.
    assign err_any_o = overrun_i | framing_i | parity_i;

    // A hit is a strobed, clean byte equal to the pattern; any other strobed byte is a miss.
    always_comb begin
        hit_o  = valid_i && (data_i == PATTERN) && !err_any_o;
        miss_o = valid_i && !hit_o;
    end

endmodule

// File: rtl/baud_tally.sv
// Event counter that wraps after LIMIT events and flags the last one.
// Assumes LIMIT >= 2; clear takes priority over increment.
module baud_tally #(
    parameter int unsigned LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int unsigned W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_q;
    logic         at_top;

    assign at_top = (cnt_q == W'(LIMIT - 1));
    assign last_o = inc_i && at_top;

    // Count events, returning to zero on clear or on the last event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i || (inc_i && at_top)) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4
    tally_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < W'(LIMIT));

endmodule

// File: rtl/baud_hunt_ctrl.sv
// Auto-baud search controller: waits for carrier, hunts down the rate
// list on a test pattern, confirms and locks.
// Assumes the receiver is re-clocked from divisor_o combinationally and
// that its flags arrive in the same cycle as the byte strobe.
module baud_hunt_ctrl #(
    parameter int unsigned       REF_HZ      = 5068800,
    parameter int unsigned       OVS         = 16,
    parameter int unsigned       IDX_W       = 4,
    parameter int unsigned       DIV_W       = 16,
    parameter int unsigned       DATA_W      = 8,
    parameter logic [DATA_W-1:0] PATTERN     = 8'h55,
    parameter int unsigned       MISS_LIMIT  = 10,
    parameter int unsigned       CONFIRM_LEN = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              carrier_det_i,
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic              rx_valid_i,
    input  logic              rx_overrun_i,
    input  logic              rx_framing_err_i,
    input  logic              rx_parity_err_i,
    output logic              dtr_o,
    output logic              rts_o,
    output logic [IDX_W-1:0]  rate_idx_o,
    output logic [DIV_W-1:0]  divisor_o,
    output logic              waiting_o,
    output logic              hunting_o,
    output logic              confirming_o,
    output logic              locked_o
);
    import baud_hunt_pkg::*;

    localparam logic [IDX_W-1:0] TOP_IDX = {IDX_W{1'b1}};

    hunt_state_t      state_q;
    logic [IDX_W-1:0] idx_q;
    logic             hs_q;
    logic             hit, miss, err_any;
    logic             miss_last, conf_last;
    logic             miss_inc, miss_clr, conf_inc, conf_clr;

    baud_byte_judge #(.DATA_W(DATA_W), .PATTERN(PATTERN)) u_judge (
        .valid_i   (rx_valid_i),
        .data_i    (rx_data_i),
        .overrun_i (rx_overrun_i),
        .framing_i (rx_framing_err_i),
        .parity_i  (rx_parity_err_i),
        .hit_o     (hit),
        .miss_o    (miss),
        .err_any_o (err_any)
    );

    // Misses at the current rate are counted only while hunting with carrier.
    always_comb begin
        miss_inc = (state_q == ST_HUNT) && carrier_det_i && miss;
        miss_clr = (state_q != ST_HUNT) || !carrier_det_i;
        conf_inc = (state_q == ST_CONFIRM) && carrier_det_i && hit;
        conf_clr = (state_q != ST_CONFIRM) || !carrier_det_i;
    end

    baud_tally #(.LIMIT(MISS_LIMIT)) u_miss (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (miss_clr),
        .inc_i  (miss_inc),
        .last_o (miss_last)
    );

    baud_tally #(.LIMIT(CONFIRM_LEN)) u_conf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (conf_clr),
        .inc_i  (conf_inc),
        .last_o (conf_last)
    );

    // Search state machine, rate index and handshake outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            idx_q   <= TOP_IDX;
            hs_q    <= 1'b0;
        end else begin
            hs_q <= 1'b1;
            if ((state_q != ST_WAIT) && !carrier_det_i) begin
                state_q <= ST_WAIT;
                idx_q   <= TOP_IDX;
            end else begin
                case (state_q)
                    ST_WAIT: begin
                        idx_q <= TOP_IDX;
                        if (carrier_det_i) state_q <= ST_HUNT;
                    end
                    ST_HUNT: begin
                        if (hit) begin
                            state_q <= ST_CONFIRM;
                        end else if (miss_last) begin
                            idx_q <= (idx_q == '0) ? TOP_IDX : idx_q - 1'b1;
                        end
                    end
                    ST_CONFIRM: begin
                        if (err_any || miss) begin
                            state_q <= ST_HUNT;
                            idx_q   <= TOP_IDX;
                        end else if (conf_last) begin
                            state_q <= ST_LOCK;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    baud_rate_rom #(.REF_HZ(REF_HZ), .OVS(OVS), .IDX_W(IDX_W), .DIV_W(DIV_W)) u_rom (
        .idx_i     (idx_q),
        .divisor_o (divisor_o)
    );

    // Drive the ports from the registered state.
    always_comb begin
        dtr_o        = hs_q;
        rts_o        = hs_q;
        rate_idx_o   = idx_q;
        waiting_o    = (state_q == ST_WAIT);
        hunting_o    = (state_q == ST_HUNT);
        confirming_o = (state_q == ST_CONFIRM);
        locked_o     = (state_q == ST_LOCK);
    end

    // R1
    handshake_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (dtr_o && rts_o));

    // R4 R5 R7
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_idx_o != $past(rate_idx_o)) |->
            ((rate_idx_o == $past(rate_idx_o) - 1'b1) || (rate_idx_o == TOP_IDX)));

    // R6
    lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(confirming_o));

    // R8
    lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && carrier_det_i) |=> ($stable(rate_idx_o) && locked_o));

    // R9
    carrier_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier_det_i |=> (waiting_o && (rate_idx_o == TOP_IDX)));

    // R11
    status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({waiting_o, hunting_o, confirming_o, locked_o}) == 1);

endmodule

// File: tb/tb_baud_hunt_ctrl.sv
module tb_baud_hunt_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cd;
    logic [7:0] data;
    logic       valid, ovr, frm, par;
    logic       dtr, rts, waiting, hunting, confirming, locked;
    logic [3:0] idx;
    logic [15:0] div;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    baud_hunt_ctrl dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .carrier_det_i    (cd),
        .rx_data_i        (data),
        .rx_valid_i       (valid),
        .rx_overrun_i     (ovr),
        .rx_framing_err_i (frm),
        .rx_parity_err_i  (par),
        .dtr_o            (dtr),
        .rts_o            (rts),
        .rate_idx_o       (idx),
        .divisor_o        (div),
        .waiting_o        (waiting),
        .hunting_o        (hunting),
        .confirming_o     (confirming),
        .locked_o         (locked)
    );

    // Expected divisor: nearest integer of 5068800 / (16 * rate).
    function automatic int exp_div(input int i);
        int rt;
        case (i)
            0: rt = 500;    1: rt = 750;    2: rt = 1100;   3: rt = 1345;
            4: rt = 1500;   5: rt = 3000;   6: rt = 6000;   7: rt = 12000;
            8: rt = 18000;  9: rt = 20000;  10: rt = 24000; 11: rt = 36000;
            12: rt = 48000; 13: rt = 72000; 14: rt = 96000; default: rt = 192000;
        endcase
        return (50688000 / 16 + rt / 2) / rt;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic o, input logic f, input logic p);
        @(negedge clk);
        data = d; valid = 1'b1; ovr = o; frm = f; par = p;
        @(negedge clk);
        valid = 1'b0; ovr = 1'b0; frm = 1'b0; par = 1'b0; data = 8'h00;
    endtask

    task automatic flag_pulse(input logic o, input logic f, input logic p);
        @(negedge clk);
        ovr = o; frm = f; par = p;
        @(negedge clk);
        ovr = 1'b0; frm = 1'b0; par = 1'b0;
    endtask

    // Misses alternate wrong values with error-flagged pattern bytes.
    task automatic misses(input int n);
        for (int k = 0; k < n; k++) begin
            if (k % 3 == 2) send(8'h55, 1'b0, 1'b1, 1'b0);
            else            send(8'h55 ^ 8'((k % 7) + 1), 1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic restart_hunt();
        @(negedge clk); cd = 1'b0;
        @(negedge clk); cd = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cd = 1'b0; data = 8'h00; valid = 1'b0;
        ovr = 1'b0; frm = 1'b0; par = 1'b0;
        repeat (3) tick();
        // R1 reset state
        chk("R1 dtr in reset", dtr, 0);
        chk("R1 rts in reset", rts, 0);
        chk("R1 idx in reset", idx, 15);
        chk("R1 waiting in reset", {waiting, hunting, confirming, locked}, 4'b1000);
        rst_n = 1'b1;
        tick();
        chk("R1 dtr after reset", dtr, 1);
        chk("R1 rts after reset", rts, 1);

        // R2 bytes and flags ignored without carrier
        repeat (4) send(8'h55, 1'b0, 1'b0, 1'b0);
        send(8'h12, 1'b1, 1'b0, 1'b0);
        chk("R2 still waiting", waiting, 1);
        chk("R2 no confirm", confirming, 0);
        chk("R2 idx", idx, 15);

        // Sweep the host over all sixteen rates.
        for (int h = 15; h >= 0; h--) begin
            @(negedge clk); cd = 1'b0;
            @(negedge clk);
            chk("R9 waiting after drop", waiting, 1);
            chk("R9 idx after drop", idx, 15);
            cd = 1'b1;
            @(negedge clk);
            chk("R3 hunting starts", hunting, 1);
            chk("R3 start idx", idx, 15);
            misses((15 - h) * 10);
            chk("R4 idx reached", idx, h);
            chk("R10 divisor", div, exp_div(h));
            send(8'h55, 1'b0, 1'b0, 1'b0);
            chk("R6 confirming", confirming, 1);
            chk("R6 idx held", idx, h);
            repeat (9) send(8'h55, 1'b0, 1'b0, 1'b0);
            chk("R6 not locked after nine", locked, 0);
            send(8'h55, 1'b0, 1'b0, 1'b0);
            chk("R6 locked after ten", locked, 1);
            send(8'hAA, 1'b0, 1'b0, 1'b0);
            flag_pulse(1'b1, 1'b1, 1'b1);
            send(8'h55, 1'b0, 1'b0, 1'b1);
            chk("R8 still locked", locked, 1);
            chk("R8 idx frozen", idx, h);
            chk("R8 divisor frozen", div, exp_div(h));
        end

        // R4 step granularity and fresh count per rate
        restart_hunt();
        misses(9);
        chk("R4 nine misses keep idx", idx, 15);
        misses(1);
        chk("R4 tenth miss steps", idx, 14);
        misses(9);
        chk("R4 count restarts per rate", idx, 14);
        misses(1);
        chk("R4 second step", idx, 13);

        // R5 wrap from slowest to fastest
        restart_hunt();
        misses(150);
        chk("R5 reached slowest", idx, 0);
        misses(10);
        chk("R5 wrap idx", idx, 15);
        chk("R5 still hunting", hunting, 1);

        // R7 wrong byte in confirmation
        restart_hunt();
        send(8'h55, 1'b0, 1'b0, 1'b0);
        repeat (3) send(8'h55, 1'b0, 1'b0, 1'b0);
        send(8'h54, 1'b0, 1'b0, 1'b0);
        chk("R7 wrong byte -> hunting", hunting, 1);
        chk("R7 wrong byte idx", idx, 15);
        misses(10);
        chk("R7 misses cleared", idx, 14);

        // R7 overrun without strobe at a lower rate
        restart_hunt();
        misses(20);
        send(8'h55, 1'b0, 1'b0, 1'b0);
        chk("R7 confirming at 13", confirming, 1);
        flag_pulse(1'b1, 1'b0, 1'b0);
        chk("R7 overrun -> hunting", hunting, 1);
        chk("R7 overrun idx", idx, 15);

        // R7 parity error with strobe
        restart_hunt();
        misses(30);
        send(8'h55, 1'b0, 1'b0, 1'b0);
        repeat (5) send(8'h55, 1'b0, 1'b0, 1'b0);
        send(8'h55, 1'b0, 1'b0, 1'b1);
        chk("R7 parity idx", idx, 15);
        chk("R7 parity hunting", hunting, 1);

        // R7 framing error without strobe
        restart_hunt();
        misses(50);
        send(8'h55, 1'b0, 1'b0, 1'b0);
        flag_pulse(1'b0, 1'b1, 1'b0);
        chk("R7 framing idx", idx, 15);

        // R9 carrier drop during confirmation
        restart_hunt();
        misses(40);
        send(8'h55, 1'b0, 1'b0, 1'b0);
        @(negedge clk); cd = 1'b0;
        @(negedge clk);
        chk("R9 drop in confirm waiting", waiting, 1);
        chk("R9 drop in confirm idx", idx, 15);

        // R11 status flags
        chk("R11 one status flag", $countones({waiting, hunting, confirming, locked}), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule